// File: doc/BRIEF.md
# Negative-Sequence Fault Direction Discriminator

This block compares two negative-sequence current phasors, one from each side of a power transformer, and classifies the disturbance as internal, external or undetermined. Both phasors arrive already referred to a common side, so ratio and phase shift have been compensated. The bias current magnitude, the base current and the three phase start flags arrive with them. The phasors are given as signed real and imaginary parts, and a one-cycle strobe marks each new sample.

The classification drives two trips. The sensitive trip is meant for turn-to-turn faults: it fires only after the internal decision has held without a break for one full fundamental cycle of samples. The unrestrained negative-sequence trip needs an internal decision together with any phase start, and it overrides the harmonic block input.

The angle window is set as cos² of the operate half-angle, so no arctangent is needed. The magnitude gate is tightened automatically when the through current is high.

Top module: `nsdir_discriminator`

## Requirements
- R1: When either phasor magnitude is not strictly greater than the active threshold, the sample is classified undetermined (dir_und=1, dir_int=0, dir_ext=0).
- R2: The active threshold is imin_set when 10·bias_mag ≤ 11·base_cur. When 10·bias_mag > 11·base_cur, it is imin_set + bias_mag/10; the comparison is exact, with no rounding.
- R3: A gated sample is internal when dot = a_re·b_re + a_im·b_im > 0 and dot²·65536 > |A|²·|B|²·cos2_set.
- R4: A gated sample that is not internal is external; this includes phasors 180° apart.
- R5: All flags and trips are 0 at reset. The flags update on the clock edge that samples smp_valid=1 and hold otherwise. After the first sample, exactly one flag is 1.
- R6: trip_sens goes to 1 on the sample edge where the SPC-th consecutive internal sample is taken. No phase start is needed. It is 0 on any sample edge where harm_blk=1.
- R7: Any sample that is not internal clears the persistence count, so trip_sens drops at that edge and needs SPC fresh internal samples to return.
- R8: trip_unres is 1 after a sample that is internal while any bit of phase_start is 1, regardless of harm_blk; otherwise it is 0.
- R9: cos2_set is unsigned Q0.16 cos² of the operate half-angle (16384 = ±60°). The window boundary itself is not internal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | New phasor sample strobe |
| a_re | input | W | Side A real part, signed |
| a_im | input | W | Side A imaginary part, signed |
| b_re | input | W | Side B real part, signed |
| b_im | input | W | Side B imaginary part, signed |
| bias_mag | input | W | Bias current magnitude |
| base_cur | input | W | Base current |
| imin_set | input | W | Minimum negative-sequence magnitude |
| cos2_set | input | 16 | cos² of operate half-angle, Q0.16 |
| phase_start | input | 3 | Per-phase start flags |
| harm_blk | input | 1 | Harmonic block for the sensitive trip |
| dir_int | output | 1 | Internal classification |
| dir_ext | output | 1 | External classification |
| dir_und | output | 1 | Undetermined classification |
| trip_sens | output | 1 | Sensitive persistent-internal trip |
| trip_unres | output | 1 | Unrestrained negative-sequence trip |

## Verification
Every output is registered on the edge that takes a sample, so each result is due exactly one clock after smp_valid is driven. The bench drives inputs on the falling edge, lets one rising edge take the sample, and reads the outputs on the next falling edge. For the persistence trip, the bench counts samples rather than cycles. It checks trip_sens after sample SPC-1 and after sample SPC, and on the edge where a single non-internal sample breaks the run.

// File: rtl/nsdir_discriminator.sv
module nsdir_discriminator #(
  parameter int W   = 16,
  parameter int SPC = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  input  logic [W-1:0]        bias_mag,
  input  logic [W-1:0]        base_cur,
  input  logic [W-1:0]        imin_set,
  input  logic [15:0]         cos2_set,
  input  logic [2:0]          phase_start,
  input  logic                harm_blk,
  output logic                dir_int,
  output logic                dir_ext,
  output logic                dir_und,
  output logic                trip_sens,
  output logic                trip_unres
);
  localparam int MW = 2*W + 2;
  localparam int TW = W + 5;
  localparam int GW = 2*TW + 8;
  localparam int PW = 4*W + 24;
  localparam int CW = $clog2(SPC + 1);

  logic signed [MW-1:0] ma_s, mb_s, dot;
  logic [GW-1:0] ma_g, mb_g, thr_sq;
  logic [TW-1:0] thr10;
  logic          raise, gate_ok, ang_ok, int_now;
  logic [PW-1:0] lhs, rhs;
  logic [CW-1:0] cnt, cnt_nx;

  assign ma_s = MW'(a_re) * MW'(a_re) + MW'(a_im) * MW'(a_im);
  assign mb_s = MW'(b_re) * MW'(b_re) + MW'(b_im) * MW'(b_im);
  assign dot  = MW'(a_re) * MW'(b_re) + MW'(a_im) * MW'(b_im);

  assign raise  = (TW'(bias_mag) * TW'(10)) > (TW'(base_cur) * TW'(11));
  assign thr10  = TW'(imin_set) * TW'(10) + (raise ? TW'(bias_mag) : TW'(0));
  assign thr_sq = GW'(thr10) * GW'(thr10);
  assign ma_g   = GW'($unsigned(ma_s)) * GW'(100);
  assign mb_g   = GW'($unsigned(mb_s)) * GW'(100);
  assign gate_ok = (ma_g > thr_sq) && (mb_g > thr_sq);

  assign lhs = (PW'($unsigned(dot)) * PW'($unsigned(dot))) << 16;
  assign rhs = PW'($unsigned(ma_s)) * PW'($unsigned(mb_s)) * PW'(cos2_set);
  assign ang_ok  = (dot > 0) && (lhs > rhs);
  assign int_now = gate_ok && ang_ok;

  assign cnt_nx = !int_now ? '0 : (cnt == CW'(SPC)) ? cnt : cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {dir_int, dir_ext, dir_und} <= 3'b000;
      trip_sens  <= 1'b0;
      trip_unres <= 1'b0;
      cnt        <= '0;
    end else if (smp_valid) begin
      dir_int    <= int_now;
      dir_ext    <= gate_ok && !ang_ok;
      dir_und    <= !gate_ok;
      cnt        <= cnt_nx;
      trip_sens  <= (cnt_nx == CW'(SPC)) && !harm_blk;
      trip_unres <= int_now && (|phase_start);
    end
  end

  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dir_int, dir_ext, dir_und}));
  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable({dir_int, dir_ext, dir_und, trip_sens, trip_unres}));
  assert_sens_internal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trip_sens |-> dir_int);
  assert_unres_internal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trip_unres |-> dir_int);
  assert_und_no_trip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dir_und |-> !trip_sens && !trip_unres);
endmodule

// File: tb/nsdir_discriminator_tb.sv
module nsdir_discriminator_tb_top;
  localparam int W = 16;
  localparam int SPC = 20;

  logic clk = 0, rst_n = 0, smp_valid = 0, harm_blk = 0;
  logic signed [W-1:0] a_re = 0, a_im = 0, b_re = 0, b_im = 0;
  logic [W-1:0] bias_mag = 0, base_cur = 10000, imin_set = 400;
  logic [15:0] cos2_set = 16384;
  logic [2:0] phase_start = 0;
  logic dir_int, dir_ext, dir_und, trip_sens, trip_unres;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nsdir_discriminator #(.W(W), .SPC(SPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .bias_mag(bias_mag), .base_cur(base_cur), .imin_set(imin_set),
    .cos2_set(cos2_set), .phase_start(phase_start), .harm_blk(harm_blk),
    .dir_int(dir_int), .dir_ext(dir_ext), .dir_und(dir_und),
    .trip_sens(trip_sens), .trip_unres(trip_unres));

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act{int,ext,und,sens,unres}=%b exp=%b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {dir_int, dir_ext, dir_und, trip_sens, trip_unres};
  endfunction

  task automatic smp(int ar, int ai, int br, int bi);
    @(negedge clk);
    a_re = W'(ar); a_im = W'(ai); b_re = W'(br); b_im = W'(bi);
    smp_valid = 1;
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R5 reset", outs(), 5'b00000);
    rst_n = 1;
    @(negedge clk);
    chk("R5 idle after reset", outs(), 5'b00000);
  endtask

  task automatic t_gate();
    bias_mag = 5000;
    smp(300, 0, 1000, 0);
    chk("R1 small A", outs(), 5'b00100);
    smp(1000, 0, 0, 300);
    chk("R1 small B", outs(), 5'b00100);
    smp(400, 0, 400, 0);
    chk("R1 equal to threshold", outs(), 5'b00100);
    smp(401, 0, 401, 0);
    chk("R1 just above threshold", outs(), 5'b10000);
  endtask

  task automatic t_bias();
    bias_mag = 20000;
    smp(1000, 0, 1000, 0);
    chk("R2 raised threshold", outs(), 5'b00100);
    smp(3000, 0, 3000, 0);
    chk("R2 above raised threshold", outs(), 5'b10000);
    bias_mag = 11000;
    smp(1000, 0, 1000, 0);
    chk("R2 bias at 110pct not raised", outs(), 5'b10000);
    bias_mag = 5000;
  endtask

  task automatic t_angle();
    smp(1000, 0, 1000, 0);
    chk("R3 in phase", outs(), 5'b10000);
    smp(1000, 0, 643, 766);
    chk("R3 R9 50deg internal", outs(), 5'b10000);
    smp(1000, 0, 342, 940);
    chk("R4 R9 70deg external", outs(), 5'b01000);
    smp(1000, 0, -1000, 0);
    chk("R4 opposite external", outs(), 5'b01000);
    smp(0, 1000, 0, 1000);
    chk("R3 in phase imaginary", outs(), 5'b10000);
    cos2_set = 16'd30000;
    smp(1000, 0, 643, 766);
    chk("R9 narrower window", outs(), 5'b01000);
    cos2_set = 16384;
  endtask

  task automatic t_hold();
    smp(1000, 0, -1000, 0);
    @(negedge clk);
    a_re = 1000; b_re = 1000;
    repeat (3) @(negedge clk);
    chk("R5 hold without strobe", outs(), 5'b01000);
  endtask

  task automatic t_persist();
    smp(0, 0, 0, 0);
    for (int i = 0; i < SPC - 1; i++) smp(1000, 0, 1000, 0);
    chk("R6 one sample short", outs(), 5'b10000);
    smp(1000, 0, 1000, 0);
    chk("R6 full cycle trip", outs(), 5'b10010);
    smp(1000, 0, -1000, 0);
    chk("R7 break clears", outs(), 5'b01000);
    smp(1000, 0, 1000, 0);
    chk("R7 restart count", outs(), 5'b10000);
    for (int i = 0; i < SPC - 2; i++) smp(1000, 0, 1000, 0);
    harm_blk = 1;
    smp(1000, 0, 1000, 0);
    chk("R6 blocked by harmonic", outs(), 5'b10000);
    harm_blk = 0;
    smp(1000, 0, 1000, 0);
    chk("R6 trip after block released", outs(), 5'b10010);
    smp(300, 0, 1000, 0);
    chk("R7 undetermined clears", outs(), 5'b00100);
  endtask

  task automatic t_unres();
    phase_start = 3'b010; harm_blk = 1;
    smp(1000, 0, 1000, 0);
    chk("R8 start plus internal despite block", outs(), 5'b10001);
    smp(1000, 0, -1000, 0);
    chk("R8 external no trip", outs(), 5'b01000);
    phase_start = 3'b000;
    smp(1000, 0, 1000, 0);
    chk("R8 no start no trip", outs(), 5'b10000);
    phase_start = 3'b100; harm_blk = 0;
    smp(1000, 0, 1000, 0);
    chk("R8 other phase start", outs(), 5'b10001);
    phase_start = 0;
  endtask

  initial begin
    t_reset();
    t_gate();
    t_bias();
    t_angle();
    t_hold();
    t_persist();
    t_unres();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog act=timeout exp=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule